// File: doc/BRIEF.md
# Reconfigurable Linear Systolic Matrix-Vector Multiplier

This block computes y = A·x for a 3x3 signed matrix A and a 3-element signed vector x using a chain of three multiply-add cells. Each cell keeps one element of x as a reconfigurable coefficient. Work happens in two phases. First, while the array is idle, the coefficients are written one at a time through a small load port. Then the matrix is streamed in, one column per cell lane, and the array advances one step on every clock where the stream is valid.

Inside each cell a data register captures the lane value. A product register multiplies the previous data value by the coefficient. A sum register adds the previous product to the incoming partial sum. The partial-sum register of each cell is loaded from the sum register of the cell before it, and the first cell receives zero. Because each cell adds two pipeline stages, lane i must carry 2·i leading zeros before its column. A frame is 9 steps long, and the last cell's sum register presents y0, y1 and y2 after steps 7, 8 and 9 of the frame.

Top module: `mvsys_top`

## Requirements
- R1: After reset, `res_valid` is 0, `res_data` is 0 and every coefficient is 0.
- R2: A frame is 9 accepted steps (steps 0 to 8). At step s, lane i (bits 16·i+15 down to 16·i of `in_lanes`) carries A[s-2i][i] when 0 ≤ s-2i ≤ 2, and zero otherwise. After the step numbered 6+j, `res_data` equals y_j = Σ_i A[j][i]·c_i, for j = 0, 1, 2.
- R3: A cycle with `in_valid` low is not a step. The lane values are ignored, `res_data` holds its value and `res_valid` is 0 in the following cycle.
- R4: `res_valid` is 1 in the cycle after frame steps 6, 7 and 8, and 0 after every other step. With an unbroken stream it is therefore high for three consecutive cycles. The step after step 8 starts a new frame.
- R5: A write with `cfg_we` high while the array is idle (no frame in progress and `in_valid` low) sets coefficient c_k to `cfg_val`, where k = `cfg_idx`. Index 3 matches no cell and is ignored.
- R6: A coefficient write made while a frame is in progress, or in a cycle where `in_valid` is high, is ignored. The running frame and later frames use the old coefficients.
- R7: Data and coefficients are 16-bit two's complement. Products are sign-extended and accumulated in 36 bits, so full-scale values (such as -32768·-32768 summed three times) are exact.
- R8: Coefficients persist across frames. Back-to-back frames with zero-padded lanes give independent results, with no residue from the previous frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Coefficient write enable |
| cfg_idx | input | 2 | Coefficient index (cell 0..2) |
| cfg_val | input | 16 | Signed coefficient value |
| in_valid | input | 1 | Stream valid; each high cycle is one array step |
| in_lanes | input | 48 | Three signed 16-bit lane values, lane i in bits 16i+15:16i |
| res_valid | output | 1 | Result element present on res_data |
| res_data | output | 36 | Signed sum register of the last cell |

## Verification
The assertions check the following on every cycle: the coefficient bank never changes while a frame is running or a step is taken, a cycle without `in_valid` leaves the result unchanged and not valid, and `res_valid` matches an independent count of steps within the frame. The arithmetic can only be shown by the bench's scenarios. These cover the skewed products reaching the right result, full-scale signed accumulation, stalls in the middle of a frame, ignored and out-of-range coefficient writes, and clean back-to-back frames. The bench sweeps coefficient triples drawn from the signed extremes, zero and small values.

// File: rtl/mvsys_pkg.sv
package mvsys_pkg;
  // number of steps in one frame for an array of n cells
  function automatic int frame_steps(input int n);
    return 3 * n;
  endfunction

  // step index (counted from 0) whose update makes the first result visible
  function automatic int first_out_step(input int n);
    return 2 * n;
  endfunction
endpackage

// File: rtl/mvsys_rst_sync.sv
module mvsys_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/mvsys_cell.sv
module mvsys_cell #(
  parameter int DW = 16,
  parameter int AW = 36
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  input  logic signed [DW-1:0] din,
  input  logic signed [DW-1:0] coef,
  input  logic signed [AW-1:0] psum_in,
  output logic signed [AW-1:0] sum_out
);
  localparam int PW = 2 * DW;

  logic signed [DW-1:0] dport_q, dport_d;
  logic signed [AW-1:0] pport_q, pport_d;
  logic signed [AW-1:0] prod_q,  prod_d;
  logic signed [AW-1:0] sum_q,   sum_d;
  logic signed [PW-1:0] mul;

  always_comb begin
    mul     = dport_q * coef;
    dport_d = dport_q;
    pport_d = pport_q;
    prod_d  = prod_q;
    sum_d   = sum_q;
    if (step) begin
      dport_d = din;
      prod_d  = AW'(mul);
      sum_d   = prod_q + pport_q;
      pport_d = psum_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dport_q <= '0;
      pport_q <= '0;
      prod_q  <= '0;
      sum_q   <= '0;
    end else begin
      dport_q <= dport_d;
      pport_q <= pport_d;
      prod_q  <= prod_d;
      sum_q   <= sum_d;
    end
  end

  assign sum_out = sum_q;
endmodule

// File: rtl/mvsys_coef.sv
module mvsys_coef #(
  parameter int N  = 3,
  parameter int DW = 16,
  parameter int IW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            idle,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [DW-1:0]   wr_val,
  output logic [N*DW-1:0] coef_flat
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    logic [DW-1:0] val_q, val_d;
    logic          hit;

    always_comb begin
      hit   = wr_en && idle && (wr_idx == IW'(g));
      val_d = hit ? wr_val : val_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= '0;
      else        val_q <= val_d;
    end

    assign coef_flat[g*DW +: DW] = val_q;
  end
endmodule

// File: rtl/mvsys_seq.sv
module mvsys_seq #(
  parameter int N = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic frame_idle,
  output logic res_valid
);
  import mvsys_pkg::*;

  localparam int FRAME = frame_steps(N);
  localparam int FIRST = first_out_step(N);
  localparam int CW    = $clog2(FRAME);
  localparam logic [CW-1:0] LAST_C  = CW'(FRAME - 1);
  localparam logic [CW-1:0] FIRST_C = CW'(FIRST);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          vld_q, vld_d;

  always_comb begin
    cnt_d = cnt_q;
    if (step) cnt_d = (cnt_q == LAST_C) ? '0 : cnt_q + 1'b1;
    vld_d = step && (cnt_q >= FIRST_C);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      vld_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      vld_q <= vld_d;
    end
  end

  assign frame_idle = (cnt_q == '0);
  assign res_valid  = vld_q;
endmodule

// File: rtl/mvsys_top.sv
module mvsys_top #(
  parameter int N  = 3,
  parameter int DW = 16,
  parameter int AW = 36,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [IW-1:0]   cfg_idx,
  input  logic [DW-1:0]   cfg_val,
  input  logic            in_valid,
  input  logic [N*DW-1:0] in_lanes,
  output logic            res_valid,
  output logic [AW-1:0]   res_data
);
  logic            rst_sync_n;
  logic            frame_idle;
  logic            cfg_open;
  logic [N*DW-1:0] coef_flat;
  logic signed [AW-1:0] chain [N+1];

  mvsys_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  mvsys_seq #(.N(N)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .step      (in_valid),
    .frame_idle(frame_idle),
    .res_valid (res_valid)
  );

  assign cfg_open = frame_idle && !in_valid;

  mvsys_coef #(.N(N), .DW(DW), .IW(IW)) u_coef (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .idle     (cfg_open),
    .wr_en    (cfg_we),
    .wr_idx   (cfg_idx),
    .wr_val   (cfg_val),
    .coef_flat(coef_flat)
  );

  assign chain[0] = '0;

  for (genvar g = 0; g < N; g++) begin : g_cell
    mvsys_cell #(.DW(DW), .AW(AW)) u_cell (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .step   (in_valid),
      .din    (in_lanes[g*DW +: DW]),
      .coef   (coef_flat[g*DW +: DW]),
      .psum_in(chain[g]),
      .sum_out(chain[g+1])
    );
  end

  assign res_data = chain[N];
endmodule

// File: rtl/mvsys_chk.sv
module mvsys_chk #(
  parameter int N  = 3,
  parameter int DW = 16,
  parameter int AW = 36
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            frame_idle,
  input logic [N*DW-1:0] coef_flat,
  input logic            res_valid,
  input logic [AW-1:0]   res_data
);
  import mvsys_pkg::*;

  localparam int FRAME = frame_steps(N);
  localparam int FIRST = first_out_step(N);
  localparam int CW    = $clog2(FRAME);

  // independent step tracker for the result window
  logic [CW-1:0] ck_cnt;
  logic          ck_win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_cnt <= '0;
      ck_win <= 1'b0;
    end else begin
      ck_win <= in_valid && (int'(ck_cnt) >= FIRST);
      if (in_valid) ck_cnt <= (int'(ck_cnt) == FRAME - 1) ? '0 : ck_cnt + 1'b1;
    end
  end

  AST_CFG_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid || !frame_idle) |=> $stable(coef_flat)); // R6

  AST_STALL_HOLDS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(res_data)); // R3

  AST_STALL_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid); // R3

  AST_VALID_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == ck_win); // R4

  AST_VALID_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(in_valid)); // R4
endmodule

bind mvsys_top mvsys_chk #(.N(N), .DW(DW), .AW(AW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .frame_idle(frame_idle),
  .coef_flat (coef_flat),
  .res_valid (res_valid),
  .res_data  (res_data)
);

// File: tb/mvsys_top_tb_top.sv
module mvsys_top_tb_top;
  localparam int N  = 3;
  localparam int DW = 16;
  localparam int AW = 36;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cfg_we;
  logic [1:0]      cfg_idx;
  logic [DW-1:0]   cfg_val;
  logic            in_valid;
  logic [N*DW-1:0] in_lanes;
  logic            res_valid;
  logic [AW-1:0]   res_data;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  longint amat [3][3];
  longint cexp [3];

  always #2 clk = ~clk;

  mvsys_top #(.N(N), .DW(DW), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_val(cfg_val), .in_valid(in_valid), .in_lanes(in_lanes),
    .res_valid(res_valid), .res_data(res_data)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint res_s();
    return longint'($signed(res_data));
  endfunction

  function automatic longint yref(input int j);
    longint acc = 0;
    for (int i = 0; i < 3; i++) acc += amat[j][i] * cexp[i];
    return acc;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // R5: write is accepted only while idle and for index 0..2
  task automatic cfg_write(input int idx, input longint val);
    cfg_we  = 1'b1;
    cfg_idx = 2'(idx);
    cfg_val = DW'(val);
    tick();
    cfg_we  = 1'b0;
    if (idx < 3) cexp[idx] = val;
  endtask

  // one 9-step frame; optional stall before step stall_at; optional ignored writes (R6)
  task automatic run_frame(input int stall_at, input bit cfg_mid);
    longint prev;
    for (int s = 0; s < 9; s++) begin
      if (s == stall_at) begin
        prev     = res_s();
        in_valid = 1'b0;
        in_lanes = {16'h7abc, 16'h8001, 16'h1234};
        tick();
        chk(res_valid == 1'b0, "R3 stall valid", longint'(res_valid), 0);
        chk(res_s() == prev, "R3 stall hold", res_s(), prev);
      end
      for (int i = 0; i < 3; i++) begin
        int r = s - 2 * i;
        in_lanes[i*DW +: DW] = (r >= 0 && r < 3) ? DW'(amat[r][i]) : '0;
      end
      in_valid = 1'b1;
      if (cfg_mid && (s == 0 || s == 4)) begin
        cfg_we  = 1'b1;
        cfg_idx = 2'(s / 4);
        cfg_val = 16'sd12345;
      end
      tick();
      cfg_we = 1'b0;
      chk(res_valid == (s >= 6), "R4 valid window", longint'(res_valid), longint'(s >= 6));
      if (s >= 6)
        chk(res_s() == yref(s - 6), "R2 result", res_s(), yref(s - 6));
    end
    in_valid = 1'b0;
    in_lanes = '0;
  endtask

  longint vals [6] = '{-32768, -1, 0, 1, 2, 32767};

  initial begin
    #600000;
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_val = '0;
    in_valid = 1'b0; in_lanes = '0;
    for (int i = 0; i < 3; i++) cexp[i] = 0;
    repeat (3) tick();
    chk(res_valid == 1'b0, "R1 reset valid", longint'(res_valid), 0);
    chk(res_s() == 0, "R1 reset data", res_s(), 0);
    rst_n = 1'b1;
    repeat (4) tick();

    // R1: coefficients are zero after reset, so results are zero
    for (int j = 0; j < 3; j++) for (int i = 0; i < 3; i++) amat[j][i] = 100 * j + i + 7;
    run_frame(-1, 1'b0);

    // example configuration (1,0,0) selects column 0
    cfg_write(0, 1); cfg_write(1, 0); cfg_write(2, 0);
    run_frame(-1, 1'b0);

    // R7: full-scale signed accumulation
    cfg_write(0, -32768); cfg_write(1, -32768); cfg_write(2, -32768);
    for (int j = 0; j < 3; j++) for (int i = 0; i < 3; i++) amat[j][i] = -32768;
    run_frame(-1, 1'b0);
    chk(res_s() == 64'sd3221225472, "R7 full scale", res_s(), 64'sd3221225472);

    // R5: index 3 ignored
    cfg_write(3, 555);
    for (int j = 0; j < 3; j++) for (int i = 0; i < 3; i++) amat[j][i] = j - i + 3;
    run_frame(-1, 1'b0);

    // R6: writes during a frame ignored; R3 stall mid-frame
    cfg_write(0, 3); cfg_write(1, -5); cfg_write(2, 7);
    run_frame(5, 1'b1);
    run_frame(7, 1'b0);  // R8: persisted coefficients, next frame after stall

    // R8 sweep: back-to-back frames over coefficient triples
    for (int a = 0; a < 6; a++)
      for (int b = 0; b < 6; b++)
        for (int c = 0; c < 6; c++) begin
          cfg_write(0, vals[a]); cfg_write(1, vals[b]); cfg_write(2, vals[c]);
          for (int j = 0; j < 3; j++)
            for (int i = 0; i < 3; i++)
              amat[j][i] = vals[(a + 2 * j + 3 * i + b + c) % 6];
          run_frame(((a + b + c) % 4 == 0) ? 6 : -1, 1'b0);
        end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule